// File: doc/BRIEF.md
# PHY Test-Bus Register Write Port

This block holds one 32-bit control word that software writes over a simple register bus. The word packs a data byte, a register address, a port number, a write-enable flag, a strobe bit and an active-low reset bit for a small test register file that sits beside each PHY port. A register is updated only when the strobe bit goes from 0 to 1 between two successive values of the control word. Software therefore performs one register update as three bus writes: it presents the fields with the strobe low, raises the strobe, then lowers it again.

The register file has one bank per port. All bank contents are brought out on a flat output vector. One bit of one register, bit 2 of register 6 on port 0, is also brought out separately as the PHY clock-enable line. While the reset bit of the control word is 0, every bank is held at zero. Port numbers or addresses outside the built configuration leave all registers unchanged. The control word itself reads back exactly as it was last written.

Top module: `phy_testbus_wport`

## Requirements
- R1: After the synchronous reset `rst`, the control word reads 0, every register of every port is 0 and `phy_clk_en` is 0.
- R2: On the cycle after a bus write, `ctrl_rdata` equals the full 32-bit word that was written, including the unused bits [20:19] and [31:24].
- R3: Control-word fields are: data [7:0], address [15:8], port [18:16], write enable bit 21, strobe bit 22, active-low test reset bit 23. When a new word carries strobe 1 and the previous word carried strobe 0, with bit 21 = 1 and bit 23 = 1, the data byte is stored into register `address` of bank `port` on the next clock edge. Register r of port p appears at `port_regs[(p*NUM_REGS+r)*8 +: 8]`.
- R4: A write happens only on the 0-to-1 change of the strobe bit. Keeping the strobe at 1 through further writes, or lowering it, stores nothing.
- R5: A strobe rise with bit 21 = 0 stores nothing.
- R6: While bit 23 of the control word is 0, every register of every port is cleared to 0 one cycle later, and a strobe rise stores nothing.
- R7: A port number of NUM_PORTS or more (2 to 7 by default) stores nothing in any bank.
- R8: An address of NUM_REGS or more stores nothing in any bank.
- R9: `phy_clk_en` equals bit 2 of register 6 of port 0.
- R10: A write changes only the single addressed register of the selected port. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register-bus write strobe for the control word |
| bus_wdata | input | 32 | Value written into the control word |
| ctrl_rdata | output | 32 | Current control word (read-back) |
| port_regs | output | NUM_PORTS*NUM_REGS*8 | All test registers of all ports, flattened |
| phy_clk_en | output | 1 | PHY clock enable, bit 2 of register 6 on port 0 |

## Verification
The bench builds the block with its defaults: two ports of eight registers each. With this configuration it can sweep all eight encodings of the 3-bit port field against addresses 0 to 9 and 255. That reaches every legal register as well as both kinds of out-of-range select, and after every step it compares the whole 128-bit register vector against a model. The small size also makes the directed corners cheap to reach in a few cycles each: a strobe held high, a rise without write enable, a clear through the reset bit, and toggling the clock-enable bit.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int PSEL_W = 3;

    // Field positions are fixed: the PHY side decodes them.
    typedef struct packed {
        logic [7:0]        upper;
        logic              trst_n;
        logic              strobe;
        logic              wen;
        logic [1:0]        spare;
        logic [PSEL_W-1:0] port;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } ctrl_word_t;

    typedef struct packed {
        logic              valid;
        logic [PSEL_W-1:0] port;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } reg_write_t;

    function automatic reg_write_t make_write(ctrl_word_t w, logic rise);
        reg_write_t r;
        r.valid = rise;
        r.port  = w.port;
        r.addr  = w.addr;
        r.data  = w.data;
        return r;
    endfunction

endpackage

// File: rtl/tbw_ctrl_reg.sv
module tbw_ctrl_reg
    import tbw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_word_t        word
);

    always_ff @(posedge clk) begin
        if (rst)     word <= '0;
        else if (we) word <= ctrl_word_t'(wdata);
    end

    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        we |=> (WORD_W'(word) == $past(wdata)));

endmodule

// File: rtl/tbw_strobe_edge.sv
module tbw_strobe_edge
    import tbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctrl_word_t word,
    output logic       rise
);

    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= word.strobe;
    end

    assign rise = word.strobe & ~strobe_q & word.wen & word.trst_n;

    // R4: a strobe held high cannot commit twice in a row
    p_single_rise_r4: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tbw_port_regs.sv
module tbw_port_regs
    import tbw_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       sel,
    input  reg_write_t                 wr,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [BYTE_W-1:0] mem [NUM_REGS];
    logic              in_range;
    logic              hit;

    assign in_range = (32'(wr.addr) < NUM_REGS);
    assign hit      = wr.valid & sel & in_range;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (hit) begin
            mem[wr.addr[IDX_W-1:0]] <= wr.data;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign regs_o[g*BYTE_W +: BYTE_W] = mem[g];
    end

    // R5/R8: without a valid, selected, in-range write the bank holds
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(wr.valid && sel && (32'(wr.addr) < NUM_REGS)) && !clear) |=> $stable(regs_o));

endmodule

// File: rtl/phy_testbus_wport.sv
module phy_testbus_wport
    import tbw_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int NUM_REGS  = 8,
    parameter int CLK_REG   = 6,
    parameter int CLK_BIT   = 2
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 bus_we,
    input  logic [31:0]                          bus_wdata,
    output logic [31:0]                          ctrl_rdata,
    output logic [NUM_PORTS*NUM_REGS*BYTE_W-1:0] port_regs,
    output logic                                 phy_clk_en
);

    localparam int BANK_W = NUM_REGS * BYTE_W;
    localparam int FLAT_W = NUM_PORTS * BANK_W;

    ctrl_word_t word;
    logic       rise;
    reg_write_t wr;

    tbw_ctrl_reg u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .wdata (bus_wdata),
        .word  (word)
    );

    tbw_strobe_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .word (word),
        .rise (rise)
    );

    assign wr = make_write(word, rise);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel = (32'(wr.port) == p);
        tbw_port_regs #(.NUM_REGS(NUM_REGS)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .clear  (~word.trst_n),
            .sel    (sel),
            .wr     (wr),
            .regs_o (port_regs[p*BANK_W +: BANK_W])
        );
    end

    assign ctrl_rdata = WORD_W'(word);
    assign phy_clk_en = port_regs[CLK_REG*BYTE_W + CLK_BIT];

    // R6: reset bit low clears every bank
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !word.trst_n |=> (port_regs == FLAT_W'(0)));

    // R7: out-of-range port leaves all banks alone
    p_bad_port_r7: assert property (@(posedge clk) disable iff (rst)
        (rise && 32'(word.port) >= NUM_PORTS) |=> $stable(port_regs));

    // R1: reset state
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ctrl_rdata == 32'd0 && port_regs == FLAT_W'(0) && !phy_clk_en));

endmodule

// File: tb/phy_testbus_wport_bench.sv
module phy_testbus_wport_bench;

    localparam int NP   = 2;
    localparam int NR   = 8;
    localparam int FLAT = NP * NR * 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            bus_we;
    logic [31:0]     bus_wdata;
    logic [31:0]     ctrl_rdata;
    logic [FLAT-1:0] port_regs;
    logic            phy_clk_en;

    int total = 0;
    int bad   = 0;

    logic [7:0] expv [NP][NR];

    always #5 clk = ~clk;

    phy_testbus_wport u_phy_testbus_wport (
        .clk        (clk),
        .rst        (rst),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .ctrl_rdata (ctrl_rdata),
        .port_regs  (port_regs),
        .phy_clk_en (phy_clk_en)
    );

    function automatic logic [31:0] mk(int port, int addr, int data,
                                       bit wen, bit stb, bit trst_n);
        return {8'h00, trst_n, stb, wen, 2'b00, 3'(port), 8'(addr), 8'(data)};
    endfunction

    function automatic logic [FLAT-1:0] exp_flat();
        logic [FLAT-1:0] v;
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NR; r++)
                v[(p*NR+r)*8 +: 8] = expv[p][r];
        return v;
    endfunction

    task automatic chk(string tag, logic [FLAT-1:0] act, logic [FLAT-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [31:0] w);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_wdata = w;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic reg_write(int port, int addr, int data, bit wen);
        bus_write(mk(port, addr, data, wen, 1'b0, 1'b1));
        bus_write(mk(port, addr, data, wen, 1'b1, 1'b1));
        bus_write(mk(port, addr, data, wen, 1'b0, 1'b1));
        if (wen && port < NP && addr < NR) expv[port][addr] = 8'(data);
    endtask

    task automatic clear_model();
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < NR; r++)
                expv[p][r] = 8'h00;
    endtask

    task automatic run_tests();
        rst = 1'b1; bus_we = 1'b0; bus_wdata = '0;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ctrl", FLAT'(ctrl_rdata), '0);
        chk("R1 regs", port_regs, '0);
        chk("R1 clk_en", FLAT'(phy_clk_en), '0);

        // R2 read-back with spare/upper bits, no commit (strobe 0)
        bus_write(32'hDE90_1234);
        chk("R2 readback", FLAT'(ctrl_rdata), FLAT'(32'hDE90_1234));
        chk("R2 regs untouched", port_regs, exp_flat());

        // R3/R7/R8/R10 sweep over all port codes and addresses
        for (int p = 0; p < 8; p++) begin
            for (int a = 0; a < NR + 3; a++) begin
                int addr = (a == NR + 2) ? 255 : a;
                reg_write(p, addr, (p*37 + addr*11 + 5) & 255, 1'b1);
                if (p >= NP)       chk("R7 bad port", port_regs, exp_flat());
                else if (addr >= NR) chk("R8 bad addr", port_regs, exp_flat());
                else               chk("R3 R10 write", port_regs, exp_flat());
            end
        end

        // R5 write enable low
        reg_write(1, 3, 8'h5A, 1'b0);
        chk("R5 no wen", port_regs, exp_flat());

        // R4 strobe held high: first rise commits, second word does not
        bus_write(mk(0, 2, 8'h11, 1'b1, 1'b0, 1'b1));
        bus_write(mk(0, 2, 8'h11, 1'b1, 1'b1, 1'b1));
        bus_write(mk(0, 2, 8'h77, 1'b1, 1'b1, 1'b1));
        expv[0][2] = 8'h11;
        chk("R4 held strobe", port_regs, exp_flat());
        bus_write(mk(0, 2, 8'h99, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        chk("R4 falling strobe", port_regs, exp_flat());

        // R9 clock enable bit
        reg_write(0, 6, 8'h04, 1'b1);
        chk("R9 clk_en on", FLAT'(phy_clk_en), FLAT'(1));
        reg_write(0, 6, 8'hFB, 1'b1);
        chk("R9 clk_en off", FLAT'(phy_clk_en), FLAT'(0));
        reg_write(1, 6, 8'h04, 1'b1);
        chk("R9 port1 no effect", FLAT'(phy_clk_en), FLAT'(0));
        reg_write(0, 6, 8'h04, 1'b1);
        chk("R9 clk_en on again", FLAT'(phy_clk_en), FLAT'(1));

        // R6 reset bit low clears, and a rise while low stores nothing
        bus_write(mk(0, 1, 8'hC3, 1'b1, 1'b0, 1'b0));
        clear_model();
        @(negedge clk);
        chk("R6 cleared", port_regs, exp_flat());
        bus_write(mk(0, 1, 8'hC3, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        chk("R6 rise ignored", port_regs, exp_flat());
        chk("R6 clk_en off", FLAT'(phy_clk_en), FLAT'(0));
        reg_write(1, 7, 8'hE1, 1'b1);
        chk("R6 R3 write after clear", port_regs, exp_flat());
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule